// File: doc/BRIEF.md
# Indexed Display Mode Register File

This block holds the control state of a graphics display mode and is reached through two 16-bit I/O ports. The index port holds a register number. The data port then reads or writes the register that the number selects. The register set covers these items:
- a version code
- horizontal and vertical resolution
- colour depth
- a mode/flag word
- a bank select
- a virtual width and a virtual height
- horizontal and vertical pan offsets

Each data write is checked before it lands. A write that breaks a rule is dropped, and a sticky error flag is raised. When the mode is switched on, the virtual width is loaded from the horizontal resolution. A virtual-width write is clamped so that one full screen height still fits in video memory. In both cases the virtual height is recomputed as the number of whole lines that fit in video memory. A capabilities flag makes the resolution and depth registers report their supported maximums instead of their stored values. A write to either pan offset produces a one-cycle refresh request.

Top module: `dispmode_regs`

## Requirements
- R1: A write with `bus_port_i`=0 loads the index. With `bus_port_i`=1, `bus_rdata_o` shows the selected register combinationally, and a write updates that register at the clock edge. With `bus_port_i`=0, `bus_rdata_o` shows the index. Register numbers are: 0 version, 1 horizontal resolution, 2 vertical resolution, 3 depth, 4 flags, 5 bank, 6 virtual width, 7 virtual height, 8 X offset, 9 Y offset. Indexes above 9 read 0, and writes to them change nothing.
- R2: The version register accepts 0xB0C0 through 0xB0C3 and reads back the accepted value. Any other value is rejected as an error and is not stored.
- R3: A horizontal resolution above 1024 is an error and is not stored. A vertical resolution above 768 is an error and is not stored.
- R4: The depth register accepts 8, 15, 16, 24 and 32. A written 0 is stored as 8. Any other value is an error and is not stored.
- R5: While flag bit 0 is set, a write to resolution or depth is an error and the register keeps its value.
- R6: `err_o` goes high in the cycle after an illegal write and stays high until reset.
- R7: The flags register stores only bits 0x01 (mode on), 0x02 (capabilities), 0x20 (8-bit DAC), 0x40 (linear framebuffer) and 0x80 (keep memory). Other bits read 0. `mode_on_o` follows bit 0. A write that takes bit 0 from 0 to 1 loads the virtual width from the horizontal resolution.
- R8: Let M be the video memory size (4 MiB) and B the bytes per pixel (1 for depth 8, 2 for 15 or 16, 3 for 24, 4 for 32). A virtual-width write W is stored as min(W, M/(vertical resolution × B)). The virtual height then becomes min(0xFFFF, M/(stored width × B)), or 0xFFFF if the stored width is 0. The same height rule applies when the width is loaded at mode-on.
- R9: Virtual height is read-only, and writes to it are ignored without raising an error.
- R10: `refresh_o` is high for exactly the cycle after each X-offset or Y-offset write.
- R11: Reset state: version 0xB0C0, 640×480, depth 8, flags 0, bank 0, virtual width 640, virtual height 6553, offsets 0, index 0, no error.
- R12: While flag bit 0x02 is set, the horizontal resolution, vertical resolution and depth registers read 1024, 768 and 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Bus access in this cycle |
| bus_write_i | input | 1 | Access is a write |
| bus_port_i | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the port chosen by `bus_port_i` |
| mode_on_o | output | 1 | Display mode enabled |
| err_o | output | 1 | Sticky illegal-write flag |
| refresh_o | output | 1 | One-cycle full-refresh request |

## Verification
The checker properties rely on only one input condition: the write strobe is taken at face value whenever `bus_valid_i` and `bus_write_i` are both high. No ordering of index and data accesses is assumed. The invariant on virtual height is claimed only while the mode is on, because only then is the depth locked. The stimulus drives every access for exactly one cycle and keeps `bus_valid_i` low between accesses. It makes each illegal write on purpose and follows it with a reset wherever the next test depends on `err_o` being clear.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int unsigned DW   = 16;
  localparam int unsigned NREG = 10;

  localparam int REG_ID   = 0;
  localparam int REG_XRES = 1;
  localparam int REG_YRES = 2;
  localparam int REG_BPP  = 3;
  localparam int REG_FLAG = 4;
  localparam int REG_BANK = 5;
  localparam int REG_VW   = 6;
  localparam int REG_VH   = 7;
  localparam int REG_XOFF = 8;
  localparam int REG_YOFF = 9;

  localparam logic [15:0] FLG_ON   = 16'h0001;
  localparam logic [15:0] FLG_CAPS = 16'h0002;
  localparam logic [15:0] FLG_DAC8 = 16'h0020;
  localparam logic [15:0] FLG_LFB  = 16'h0040;
  localparam logic [15:0] FLG_KEEP = 16'h0080;
  localparam logic [15:0] FLG_MASK = FLG_ON | FLG_CAPS | FLG_DAC8 | FLG_LFB | FLG_KEEP;

  localparam logic [15:0] VER_LO = 16'hB0C0;
  localparam logic [15:0] VER_HI = 16'hB0C3;

  function automatic logic [2:0] depth_bytes(input logic [15:0] d);
    case (d)
      16'd15, 16'd16: depth_bytes = 3'd2;
      16'd24:         depth_bytes = 3'd3;
      16'd32:         depth_bytes = 3'd4;
      default:        depth_bytes = 3'd1;
    endcase
  endfunction

  function automatic logic depth_legal(input logic [15:0] d);
    case (d)
      16'd0, 16'd8, 16'd15, 16'd16, 16'd24, 16'd32: depth_legal = 1'b1;
      default:                                      depth_legal = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dm_port_if.sv
module dm_port_if
  import dm_pkg::*;
#(
  parameter int unsigned N = NREG
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          write_i,
  input  logic          port_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] idx_o,
  output logic [N-1:0]  wsel_o
);
  logic [DW-1:0] idx_q;
  logic          dwr;

  assign dwr   = valid_i & write_i & port_i;
  assign idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         idx_q <= '0;
    else if (valid_i & write_i & ~port_i) idx_q <= wdata_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_sel
    assign wsel_o[g] = dwr && (idx_q == DW'(g));
  end
endmodule

// File: rtl/dm_write_check.sv
module dm_write_check
  import dm_pkg::*;
#(
  parameter int unsigned MAX_X = 1024,
  parameter int unsigned MAX_Y = 768
) (
  input  logic [NREG-1:0] wsel_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            mode_on_i,
  output logic [NREG-1:0] accept_o,
  output logic            illegal_o,
  output logic [DW-1:0]   depth_o
);
  logic [NREG-1:0] legal;
  logic [NREG-1:0] ro_mask;

  always_comb begin
    legal           = '1;
    legal[REG_ID]   = (wdata_i >= VER_LO) && (wdata_i <= VER_HI);
    legal[REG_XRES] = !mode_on_i && (wdata_i <= DW'(MAX_X));
    legal[REG_YRES] = !mode_on_i && (wdata_i <= DW'(MAX_Y));
    legal[REG_BPP]  = !mode_on_i && depth_legal(wdata_i);
    ro_mask         = '0;
    ro_mask[REG_VH] = 1'b1;
  end

  assign accept_o  = wsel_i & legal & ~ro_mask;
  assign illegal_o = |(wsel_i & ~legal);
  assign depth_o   = (wdata_i == '0) ? DW'(8) : wdata_i;
endmodule

// File: rtl/dm_vheight.sv
module dm_vheight
  import dm_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 4194304
) (
  input  logic [DW-1:0] src_w_i,
  input  logic [2:0]    bytes_i,
  input  logic [DW-1:0] yres_i,
  output logic [DW-1:0] w_adj_o,
  output logic [DW-1:0] h_o
);
  localparam logic [31:0] MEM_W = 32'(MEM_BYTES);
  localparam logic [31:0] CAP   = 32'h0000_FFFF;

  logic [31:0] den_y, lim_raw, lim;
  logic [31:0] den_w, h_raw;

  always_comb begin
    den_y   = 32'(yres_i) * 32'(bytes_i);
    lim_raw = (den_y == '0) ? CAP : MEM_W / ((den_y == '0) ? 32'd1 : den_y);
    lim     = (lim_raw > CAP) ? CAP : lim_raw;
    w_adj_o = (32'(src_w_i) > lim) ? lim[DW-1:0] : src_w_i;
    den_w   = 32'(w_adj_o) * 32'(bytes_i);
    h_raw   = (den_w == '0) ? CAP : MEM_W / ((den_w == '0) ? 32'd1 : den_w);
    h_o     = (h_raw > CAP) ? CAP[DW-1:0] : h_raw[DW-1:0];
  end
endmodule

// File: rtl/dispmode_regs.sv
module dispmode_regs
  import dm_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 4194304,
  parameter int unsigned MAX_X     = 1024,
  parameter int unsigned MAX_Y     = 768,
  parameter int unsigned MAX_BPP   = 32,
  parameter int unsigned RST_X     = 640,
  parameter int unsigned RST_Y     = 480
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_valid_i,
  input  logic        bus_write_i,
  input  logic        bus_port_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  output logic        mode_on_o,
  output logic        err_o,
  output logic        refresh_o
);
  localparam int unsigned RST_VH_F = MEM_BYTES / RST_X;
  localparam int unsigned RST_VH   = (RST_VH_F > 65535) ? 65535 : RST_VH_F;

  logic [DW-1:0]   idx_q;
  logic [NREG-1:0] wsel, acc;
  logic            illegal;
  logic [DW-1:0]   depth_n, src_w, w_adj, vh_new, reg_rd;
  logic            go_on;

  logic [DW-1:0] id_q, xres_q, yres_q, bpp_q, flags_q, bank_q;
  logic [DW-1:0] vw_q, vh_q, xoff_q, yoff_q;
  logic          err_q, refresh_q;

  dm_port_if #(.N(NREG)) u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (bus_valid_i),
    .write_i (bus_write_i),
    .port_i  (bus_port_i),
    .wdata_i (bus_wdata_i),
    .idx_o   (idx_q),
    .wsel_o  (wsel)
  );

  dm_write_check #(.MAX_X(MAX_X), .MAX_Y(MAX_Y)) u_chk_wr (
    .wsel_i    (wsel),
    .wdata_i   (bus_wdata_i),
    .mode_on_i (flags_q[0]),
    .accept_o  (acc),
    .illegal_o (illegal),
    .depth_o   (depth_n)
  );

  // mode-on edge reloads the virtual width from the horizontal resolution
  assign go_on = acc[REG_FLAG] && bus_wdata_i[0] && !flags_q[0];
  assign src_w = go_on ? xres_q : bus_wdata_i;

  dm_vheight #(.MEM_BYTES(MEM_BYTES)) u_vh (
    .src_w_i (src_w),
    .bytes_i (depth_bytes(bpp_q)),
    .yres_i  (yres_q),
    .w_adj_o (w_adj),
    .h_o     (vh_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q      <= VER_LO;
      xres_q    <= DW'(RST_X);
      yres_q    <= DW'(RST_Y);
      bpp_q     <= DW'(8);
      flags_q   <= '0;
      bank_q    <= '0;
      vw_q      <= DW'(RST_X);
      vh_q      <= DW'(RST_VH);
      xoff_q    <= '0;
      yoff_q    <= '0;
      err_q     <= 1'b0;
      refresh_q <= 1'b0;
    end else begin
      refresh_q <= acc[REG_XOFF] | acc[REG_YOFF];
      if (illegal)        err_q   <= 1'b1;
      if (acc[REG_ID])    id_q    <= bus_wdata_i;
      if (acc[REG_XRES])  xres_q  <= bus_wdata_i;
      if (acc[REG_YRES])  yres_q  <= bus_wdata_i;
      if (acc[REG_BPP])   bpp_q   <= depth_n;
      if (acc[REG_FLAG])  flags_q <= bus_wdata_i & FLG_MASK;
      if (acc[REG_BANK])  bank_q  <= bus_wdata_i;
      if (acc[REG_VW] || go_on) begin
        vw_q <= w_adj;
        vh_q <= vh_new;
      end
      if (acc[REG_XOFF])  xoff_q  <= bus_wdata_i;
      if (acc[REG_YOFF])  yoff_q  <= bus_wdata_i;
    end
  end

  always_comb begin
    case (idx_q)
      16'd0:   reg_rd = id_q;
      16'd1:   reg_rd = flags_q[1] ? DW'(MAX_X)   : xres_q;
      16'd2:   reg_rd = flags_q[1] ? DW'(MAX_Y)   : yres_q;
      16'd3:   reg_rd = flags_q[1] ? DW'(MAX_BPP) : bpp_q;
      16'd4:   reg_rd = flags_q;
      16'd5:   reg_rd = bank_q;
      16'd6:   reg_rd = vw_q;
      16'd7:   reg_rd = vh_q;
      16'd8:   reg_rd = xoff_q;
      16'd9:   reg_rd = yoff_q;
      default: reg_rd = '0;
    endcase
  end

  assign bus_rdata_o = bus_port_i ? reg_rd : idx_q;
  assign mode_on_o   = flags_q[0];
  assign err_o       = err_q;
  assign refresh_o   = refresh_q;
endmodule

// File: rtl/dm_checker.sv
module dm_checker #(
  parameter int unsigned MEM_BYTES = 4194304,
  parameter int unsigned MAX_X     = 1024,
  parameter int unsigned MAX_Y     = 768
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_valid_i,
  input logic        bus_write_i,
  input logic        bus_port_i,
  input logic [15:0] idx_q,
  input logic [15:0] xres_q,
  input logic [15:0] yres_q,
  input logic [15:0] bpp_q,
  input logic [15:0] vw_q,
  input logic [15:0] vh_q,
  input logic        mode_on_o,
  input logic        err_o,
  input logic        refresh_o
);
  logic [2:0]  bytes;
  logic [47:0] area;

  always_comb begin
    case (bpp_q)
      16'd15, 16'd16: bytes = 3'd2;
      16'd24:         bytes = 3'd3;
      16'd32:         bytes = 3'd4;
      default:        bytes = 3'd1;
    endcase
    area = 48'(vh_q) * 48'(vw_q) * 48'(bytes);
  end

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_geom_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xres_q <= 16'(MAX_X)) && (yres_q <= 16'(MAX_Y)));

  assert_depth_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bpp_q == 16'd8) || (bpp_q == 16'd15) || (bpp_q == 16'd16) ||
    (bpp_q == 16'd24) || (bpp_q == 16'd32));

  assert_geom_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_on_o |=> ($stable(xres_q) && $stable(yres_q) && $stable(bpp_q)));

  assert_vh_fit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_on_o && vw_q != '0) |-> (area <= 48'(MEM_BYTES)));

  assert_refresh_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |-> $past(bus_valid_i && bus_write_i && bus_port_i &&
                        (idx_q == 16'd8 || idx_q == 16'd9)));
endmodule

bind dispmode_regs dm_checker #(
  .MEM_BYTES (MEM_BYTES),
  .MAX_X     (MAX_X),
  .MAX_Y     (MAX_Y)
) u_dm_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_valid_i (bus_valid_i),
  .bus_write_i (bus_write_i),
  .bus_port_i  (bus_port_i),
  .idx_q       (idx_q),
  .xres_q      (xres_q),
  .yres_q      (yres_q),
  .bpp_q       (bpp_q),
  .vw_q        (vw_q),
  .vh_q        (vh_q),
  .mode_on_o   (mode_on_o),
  .err_o       (err_o),
  .refresh_o   (refresh_o)
);

// File: tb/tb_dispmode_regs.sv
`timescale 1ns/1ps
module tb_dispmode_regs;
  localparam int MEM = 4194304;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        bus_valid_i = 0, bus_write_i = 0, bus_port_i = 0;
  logic [15:0] bus_wdata_i = 0;
  logic [15:0] bus_rdata_o;
  logic        mode_on_o, err_o, refresh_o;

  dispmode_regs dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_valid_i(bus_valid_i),
    .bus_write_i(bus_write_i), .bus_port_i(bus_port_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .mode_on_o(mode_on_o), .err_o(err_o), .refresh_o(refresh_o)
  );

  always #5 clk_i = ~clk_i;

  int total = 0, bad = 0, cycles = 0;
  bit run = 0;
  int m_id, m_x, m_y, m_b, m_en, m_bank, m_vw, m_vh, m_xo, m_yo, m_idx;
  bit m_err, m_ref;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int bpb(int b);
    if (b == 15 || b == 16) return 2;
    if (b == 24) return 3;
    if (b == 32) return 4;
    return 1;
  endfunction

  function automatic int fit_w(int w);
    int lim;
    lim = (m_y == 0) ? 65535 : MEM / (m_y * bpb(m_b));
    if (lim > 65535) lim = 65535;
    return (w > lim) ? lim : w;
  endfunction

  function automatic int h_of(int w);
    int h;
    if (w == 0) return 65535;
    h = MEM / (w * bpb(m_b));
    return (h > 65535) ? 65535 : h;
  endfunction

  function automatic int mread(int idx);
    bit caps;
    caps = (m_en & 2) != 0;
    case (idx)
      0: return m_id;
      1: return caps ? 1024 : m_x;
      2: return caps ? 768 : m_y;
      3: return caps ? 32 : m_b;
      4: return m_en;
      5: return m_bank;
      6: return m_vw;
      7: return m_vh;
      8: return m_xo;
      9: return m_yo;
      default: return 0;
    endcase
  endfunction

  function automatic void mreset();
    m_id = 'hB0C0; m_x = 640; m_y = 480; m_b = 8; m_en = 0; m_bank = 0;
    m_vw = 640; m_vh = MEM / 640; m_xo = 0; m_yo = 0; m_idx = 0;
    m_err = 0; m_ref = 0;
  endfunction

  function automatic void mapply(bit port, int d);
    bit on;
    if (!port) begin m_idx = d; m_ref = 0; return; end
    on = (m_en & 1) != 0;
    m_ref = (m_idx == 8 || m_idx == 9);
    case (m_idx)
      0: if (d >= 'hB0C0 && d <= 'hB0C3) m_id = d; else m_err = 1;
      1: if (!on && d <= 1024) m_x = d; else m_err = 1;
      2: if (!on && d <= 768) m_y = d; else m_err = 1;
      3: if (!on && (d == 0 || d == 8 || d == 15 || d == 16 || d == 24 || d == 32))
           m_b = (d == 0) ? 8 : d;
         else m_err = 1;
      4: begin
           if (!on && (d & 1)) begin m_vw = fit_w(m_x); m_vh = h_of(m_vw); end
           m_en = d & 'hE3;
         end
      5: m_bank = d;
      6: begin m_vw = fit_w(d); m_vh = h_of(m_vw); end
      8: m_xo = d;
      9: m_yo = d;
      default: ;
    endcase
  endfunction

  task automatic wr(bit port, int d);
    @(negedge clk_i);
    bus_valid_i = 1; bus_write_i = 1; bus_port_i = port; bus_wdata_i = 16'(d);
    @(posedge clk_i); #1;
    mapply(port, d);
    bus_valid_i = 0; bus_write_i = 0;
  endtask

  task automatic wreg(int idx, int d);
    wr(0, idx);
    wr(1, d);
  endtask

  task automatic rd(int idx, string tag);
    wr(0, idx);
    bus_port_i = 1;
    @(negedge clk_i);
    chk(tag, int'(bus_rdata_o), mread(idx));
  endtask

  task automatic do_reset();
    run = 0;
    rst_ni = 0;
    @(negedge clk_i); @(negedge clk_i);
    mreset();
    rst_ni = 1;
    @(negedge clk_i);
    run = 1;
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    cycles++;
    if (run) begin
      chk("R6 err", int'(err_o), int'(m_err));
      chk("R10 refresh", int'(refresh_o), int'(m_ref));
      chk("R7 mode_on", int'(mode_on_o), m_en & 1);
    end
  end

  initial begin
    wait (cycles > 150000);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=done", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    for (int i = 0; i < 10; i++) rd(i, "R11 reset");
    chk("R11 err", int'(err_o), 0);
    // R1 index readback and undefined indexes
    wr(0, 9); bus_port_i = 0; @(negedge clk_i); chk("R1 index", int'(bus_rdata_o), 9);
    wreg(12, 'h1234); rd(12, "R1 undef");
    for (int i = 0; i < 10; i++) rd(i, "R1 undef no-touch");
    chk("R1 no err", int'(err_o), 0);
    // R4 depth
    wreg(3, 16); rd(3, "R4 d16");
    wreg(3, 0);  rd(3, "R4 zero->8");
    wreg(3, 24); rd(3, "R4 d24");
    wreg(3, 32); rd(3, "R4 d32");
    wreg(3, 12); rd(3, "R4 bad kept");
    chk("R6 set", int'(err_o), 1);
    wreg(3, 8); rd(3, "R4 d8");
    chk("R6 sticky", int'(err_o), 1);
    do_reset();
    // R3 resolution limits
    wreg(1, 1024); rd(1, "R3 x max");
    wreg(2, 768);  rd(2, "R3 y max");
    chk("R3 no err", int'(err_o), 0);
    wreg(1, 1025); rd(1, "R3 x over");
    wreg(2, 769);  rd(2, "R3 y over");
    do_reset();
    // R2 version
    wreg(0, 'hB0C3); rd(0, "R2 ok");
    chk("R2 no err", int'(err_o), 0);
    wreg(0, 'hB0C4); rd(0, "R2 hi");
    wreg(0, 'hB0BF); rd(0, "R2 lo");
    do_reset();
    // R7 mode on, R8 loading and clamping
    wreg(1, 800); wreg(2, 600); wreg(3, 16);
    wreg(6, 123); rd(6, "R8 vw"); rd(7, "R8 vh");
    wreg(4, 'hFF); rd(4, "R7 mask");
    rd(6, "R7 vw load"); rd(7, "R8 vh load");
    // R5 lock
    wreg(1, 640); rd(1, "R5 x lock");
    wreg(2, 480); rd(2, "R5 y lock");
    wreg(3, 8);   rd(3, "R5 d lock");
    chk("R5 err", int'(err_o), 1);
    do_reset();
    wreg(2, 768); wreg(3, 32);
    wreg(6, 2000); rd(6, "R8 clamp"); rd(7, "R8 clamp vh");
    wreg(6, 0);    rd(7, "R8 zero w");
    wreg(3, 8); wreg(6, 100); rd(6, "R8 narrow"); rd(7, "R8 cap");
    // R9 read-only height
    wreg(7, 5); rd(7, "R9 ro");
    chk("R9 no err", int'(err_o), 0);
    // R10 offsets and bank
    wreg(8, 33); rd(8, "R10 xoff");
    wreg(9, 44); rd(9, "R10 yoff");
    wr(0, 8); wr(1, 1); wr(1, 2); rd(8, "R10 b2b");
    wreg(5, 7); rd(5, "R1 bank");
    // R12 capabilities
    wreg(4, 'h03);
    rd(1, "R12 x"); rd(2, "R12 y"); rd(3, "R12 d");
    wreg(4, 'h00); rd(1, "R12 off");
    chk("R12 no err", int'(err_o), 0);
    run = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule